// File: doc/BRIEF.md
# Dual-Lane Command NOR Flash Model

This block is a synthesizable model of a command-driven NOR flash as it appears on a 32-bit bus built from two 16-bit devices side by side. Each 16-bit lane is a complete device. It has its own command decoder, read mode, status register, block lock bits and storage. Both lanes see the same bus address. A bus write hands each lane its own 16-bit half. The low byte of that half is the lane's command byte, the confirm code of a two-cycle sequence, or program data.

Bus reads return, per lane, array contents, identifier data or the status register, depending on that lane's read mode. Word programming takes a parameterizable busy interval, during which the ready bit of the status register reads low. Blocks can be locked and unlocked. A program or erase aimed at a locked block is refused and flagged in the status register until software clears it. A host driver uses the block the usual way: it sends a command, then polls status until both lanes report ready.

The write channel is a valid/ready stream. `wr_ready` is held high, so every write with `wr_valid` is taken in the cycle it is presented. The read channel is a request/response stream without back-pressure: each request with `rd_valid` yields exactly one `rsp_valid` pulse one cycle later, and the response must be taken then.

Top module: `nor_flash_pair`

## Requirements
- R1: After reset, every block of each lane is locked, each lane is in array-read mode, each lane's status register is 0x80, and every stored word reads 0xFFFF per lane.
- R2: Each lane takes a command from the low byte of its half of the write data. The read modes are: 0xFF array, 0x70 status (the lane reads the status byte in bits 7:0 with its upper 8 bits zero), 0x90 identifier, and 0x98 query (reads zero). In identifier mode, read address bits 1:0 select the value: 0 gives MFR_ID, 1 gives DEV_ID, 2 gives the lock bit of the addressed block in bit 0, and 3 gives zero. An unrecognised command byte changes nothing.
- R3: Lane 0 occupies bus bits 15:0 and lane 1 occupies bits 31:16. The lanes keep fully separate state, so the ready bits of a status read are bus bits 7 and 23.
- R4: Command 0x40 followed by a data write programs the addressed word with the bitwise AND of its old value and the data. The lane then enters status-read mode.
- R5: For PROG_CYCLES cycles after the data write of an accepted program, the lane's ready bit (status bit 7) reads 0. It then returns to 1, and the new word is visible in the same cycle. During that interval every write except 0x70 is ignored by that lane.
- R6: A program aimed at a locked block leaves the array unchanged and sets status bit 4 (program error) and bit 1 (block locked). These bits stay set until a 0x50 command clears status bits 5, 4, 3 and 1. Command 0x50 keeps the ready bit and leaves the read mode unchanged.
- R7: Command 0x60 followed by 0x01 locks the block addressed by the second write, and 0x60 followed by 0xD0 unlocks it. Any other second byte changes no lock. In every case the lane enters status-read mode. The block index is address bits ADDR_W-1:BLK_SHIFT.
- R8: Command 0x20 followed by 0xD0 sets every word of the addressed block to 0xFFFF if that block is unlocked. If the block is locked, it sets status bits 5 and 1 and leaves the array unchanged. Any other second byte cancels the erase. In every case the lane enters status-read mode.
- R9: After a program, the lane stays in status-read mode until a 0xFF command returns it to array-read mode.
- R10: `wr_ready` is always high, and `rsp_valid` follows each `rd_valid` by exactly one cycle. The response returns the state from before any write in the same cycle.
- R11: Status bits 6, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat accepted (always high) |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | LANES*LANE_W | Command, confirm code or program data, one half per lane |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | LANES*LANE_W | Read response, one half per lane |

## Verification
A read response is due one clock after its request. It reflects the lane state from before any write presented in the same cycle. A program's ready bit falls one edge after the data write and rises PROG_CYCLES edges later, together with the updated word. The bench drives inputs on the falling edge and advances a behavioural two-lane model at that moment. It keeps the expected response of each request until the next falling edge, then compares `rsp_valid` and `rsp_data` against it. Every clock is checked this way, so the exact cycles of busy, ready and the lock and erase outcomes are all pinned.

// File: rtl/nor_pkg.sv
package nor_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_e;
  typedef enum logic [1:0] {PD_NONE, PD_PROG, PD_LOCK, PD_ERASE} pend_e;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_QRY   = 8'h98;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR_STAT   = 8'h50;
  localparam logic [7:0] OP_PROGRAM    = 8'h40;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_LOCK_SETUP = 8'h60;
  localparam logic [7:0] OP_LOCK_BLK   = 8'h01;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;

  localparam int ST_RDY  = 7;
  localparam int ST_EERR = 5;
  localparam int ST_PERR = 4;
  localparam int ST_VERR = 3;
  localparam int ST_BLK  = 1;
endpackage

// File: rtl/nor_store.sv
module nor_store #(
  parameter int LANE_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int BLK_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [LANE_W-1:0]           rd_word,
  output logic                        rd_locked,
  input  logic [ADDR_W-1:0]           wa_addr,
  output logic                        wa_locked,
  input  logic                        prog_en,
  input  logic [ADDR_W-1:0]           prog_addr,
  input  logic [LANE_W-1:0]           prog_data,
  input  logic                        erase_en,
  input  logic                        lock_set,
  input  logic                        lock_clr,
  input  logic [ADDR_W-BLK_SHIFT-1:0] blk_sel
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK_W = ADDR_W - BLK_SHIFT;
  localparam int NBLK  = 1 << BLK_W;

  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [NBLK-1:0]   lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_en && ((i >> BLK_SHIFT) == int'(blk_sel)))
          mem_q[i] <= '1;
        else if (prog_en && (i == int'(prog_addr)))
          mem_q[i] <= mem_q[i] & prog_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lock_q <= '1;
    else if (lock_set) lock_q[blk_sel] <= 1'b1;
    else if (lock_clr) lock_q[blk_sel] <= 1'b0;
  end

  assign rd_word   = mem_q[rd_addr];
  assign rd_locked = lock_q[rd_addr[ADDR_W-1:BLK_SHIFT]];
  assign wa_locked = lock_q[wa_addr[ADDR_W-1:BLK_SHIFT]];

  // R6
  prog_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> !lock_q[prog_addr[ADDR_W-1:BLK_SHIFT]]);
  // R8
  erase_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> !lock_q[blk_sel]);
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int          LANE_W      = 16,
  parameter int          ADDR_W      = 6,
  parameter int          BLK_SHIFT   = 4,
  parameter int          PROG_CYCLES = 3,
  parameter logic [15:0] MFR_ID      = 16'h00A5,
  parameter logic [15:0] DEV_ID      = 16'h5A17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [LANE_W-1:0]           wr_word,
  input  logic [1:0]                  rd_off,
  input  logic [LANE_W-1:0]           arr_word,
  input  logic                        arr_locked,
  input  logic                        wa_locked,
  output logic                        prog_en,
  output logic [ADDR_W-1:0]           prog_addr,
  output logic [LANE_W-1:0]           prog_data,
  output logic                        erase_en,
  output logic                        lock_set,
  output logic                        lock_clr,
  output logic [ADDR_W-BLK_SHIFT-1:0] blk_sel,
  output logic [LANE_W-1:0]           rd_lane
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 2);

  rmode_e            mode_q, mode_d;
  pend_e             pend_q, pend_d;
  logic [7:0]        stat_q, stat_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [LANE_W-1:0] pdata_q, pdata_d;
  logic [7:0]        cmd;
  logic              busy;
  logic              clr_now;

  assign cmd     = wr_word[7:0];
  assign busy    = (cnt_q != '0);
  assign blk_sel = wr_addr[ADDR_W-1:BLK_SHIFT];
  assign clr_now = wr_en && !busy && (pend_q == PD_NONE) && (cmd == OP_CLR_STAT);

  always_comb begin
    mode_d    = mode_q;
    pend_d    = pend_q;
    stat_d    = stat_q;
    cnt_d     = cnt_q;
    paddr_d   = paddr_q;
    pdata_d   = pdata_q;
    prog_en   = 1'b0;
    prog_addr = paddr_q;
    prog_data = pdata_q;
    erase_en  = 1'b0;
    lock_set  = 1'b0;
    lock_clr  = 1'b0;
    if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        prog_en        = 1'b1;
        stat_d[ST_RDY] = 1'b1;
      end
      if (wr_en && (cmd == OP_READ_STAT)) mode_d = RM_STATUS;
    end else if (wr_en) begin
      pend_d = PD_NONE;
      case (pend_q)
        PD_PROG: begin
          mode_d = RM_STATUS;
          if (wa_locked) begin
            stat_d[ST_PERR] = 1'b1;
            stat_d[ST_BLK]  = 1'b1;
          end else if (PROG_CYCLES == 0) begin
            prog_en   = 1'b1;
            prog_addr = wr_addr;
            prog_data = wr_word;
          end else begin
            cnt_d          = CNT_W'(PROG_CYCLES);
            paddr_d        = wr_addr;
            pdata_d        = wr_word;
            stat_d[ST_RDY] = 1'b0;
          end
        end
        PD_LOCK: begin
          mode_d = RM_STATUS;
          if (cmd == OP_LOCK_BLK)     lock_set = 1'b1;
          else if (cmd == OP_CONFIRM) lock_clr = 1'b1;
        end
        PD_ERASE: begin
          mode_d = RM_STATUS;
          if (cmd == OP_CONFIRM) begin
            if (wa_locked) begin
              stat_d[ST_EERR] = 1'b1;
              stat_d[ST_BLK]  = 1'b1;
            end else begin
              erase_en = 1'b1;
            end
          end
        end
        default: begin
          case (cmd)
            OP_READ_ARRAY: mode_d = RM_ARRAY;
            OP_READ_ID:    mode_d = RM_IDENT;
            OP_READ_QRY:   mode_d = RM_QUERY;
            OP_READ_STAT:  mode_d = RM_STATUS;
            OP_CLR_STAT: begin
              stat_d[ST_EERR] = 1'b0;
              stat_d[ST_PERR] = 1'b0;
              stat_d[ST_VERR] = 1'b0;
              stat_d[ST_BLK]  = 1'b0;
            end
            OP_PROGRAM:    pend_d = PD_PROG;
            OP_LOCK_SETUP: pend_d = PD_LOCK;
            OP_ERASE:      pend_d = PD_ERASE;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= RM_ARRAY;
      pend_q  <= PD_NONE;
      stat_q  <= 8'h80;
      cnt_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      stat_q  <= stat_d;
      cnt_q   <= cnt_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
  end

  always_comb begin
    rd_lane = '0;
    case (mode_q)
      RM_ARRAY:  rd_lane = arr_word;
      RM_STATUS: rd_lane = {{(LANE_W-8){1'b0}}, stat_q};
      RM_IDENT: begin
        case (rd_off)
          2'd0:    rd_lane = LANE_W'(MFR_ID);
          2'd1:    rd_lane = LANE_W'(DEV_ID);
          2'd2:    rd_lane = {{(LANE_W-1){1'b0}}, arr_locked};
          default: rd_lane = '0;
        endcase
      end
      default:   rd_lane = '0;
    endcase
  end

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stat_q[ST_RDY]);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(PROG_CYCLES));
  // R6
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_PERR] && !clr_now) |=> stat_q[ST_PERR]);
  // R11
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[6] == 1'b0 && stat_q[2] == 1'b0 && stat_q[0] == 1'b0);
endmodule

// File: rtl/nor_flash_pair.sv
module nor_flash_pair #(
  parameter int          LANES       = 2,
  parameter int          LANE_W      = 16,
  parameter int          ADDR_W      = 6,
  parameter int          BLK_SHIFT   = 4,
  parameter int          PROG_CYCLES = 3,
  parameter logic [15:0] MFR_ID      = 16'h00A5,
  parameter logic [15:0] DEV_ID      = 16'h5A17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_valid,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_data
);
  localparam int BUS_W = LANES * LANE_W;
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [BUS_W-1:0] rd_bus;
  logic             wr_en;

  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] arr_word, lane_rd, prog_data;
    logic [ADDR_W-1:0] prog_addr;
    logic [BLK_W-1:0]  blk_sel;
    logic              arr_locked, wa_locked, prog_en, erase_en, lock_set, lock_clr;

    nor_cmd_fsm #(
      .LANE_W(LANE_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT),
      .PROG_CYCLES(PROG_CYCLES), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) i_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_word(wr_data[l*LANE_W +: LANE_W]), .rd_off(rd_addr[1:0]),
      .arr_word(arr_word), .arr_locked(arr_locked), .wa_locked(wa_locked),
      .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_en(erase_en), .lock_set(lock_set), .lock_clr(lock_clr),
      .blk_sel(blk_sel), .rd_lane(lane_rd)
    );

    nor_store #(
      .LANE_W(LANE_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)
    ) i_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_word(arr_word),
      .rd_locked(arr_locked), .wa_addr(wr_addr), .wa_locked(wa_locked),
      .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_en(erase_en), .lock_set(lock_set), .lock_clr(lock_clr),
      .blk_sel(blk_sel)
    );

    assign rd_bus[l*LANE_W +: LANE_W] = lane_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp_data <= rd_bus;
    end
  end
endmodule

// File: tb/test_nor_flash_pair.sv
module test_nor_flash_pair;
  localparam int PC = 3;
  localparam logic [15:0] MID = 16'h00A5;
  localparam logic [15:0] DID = 16'h5A17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  always #10 clk = ~clk;

  nor_flash_pair #(.PROG_CYCLES(PC), .MFR_ID(MID), .DEV_ID(DID)) i_nor_flash_pair (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural model, per lane
  logic [15:0] m_mem [2][64];
  bit          m_lk  [2][4];
  logic [7:0]  m_st  [2];
  int          m_md  [2];   // 0 array, 1 status, 2 ident, 3 query
  int          m_pd  [2];   // 0 none, 1 program, 2 lock, 3 erase
  int          m_cnt [2];
  int          m_pa  [2];
  logic [15:0] m_pdat[2];

  bit          exp_v = 1'b0;
  logic [31:0] exp_d = '0;
  string       exp_tag = "R10";

  function automatic logic [15:0] mread(int ln, int a);
    case (m_md[ln])
      0: return m_mem[ln][a];
      1: return {8'h00, m_st[ln]};
      2: begin
        case (a & 3)
          0: return MID;
          1: return DID;
          2: return {15'd0, m_lk[ln][a >> 4]};
          default: return 16'h0;
        endcase
      end
      default: return 16'h0;
    endcase
  endfunction

  task automatic mlane(int ln, bit wv, int wa, logic [15:0] d);
    logic [7:0] c;
    int p;
    c = d[7:0];
    if (m_cnt[ln] > 0) begin
      m_cnt[ln]--;
      if (m_cnt[ln] == 0) begin
        m_mem[ln][m_pa[ln]] &= m_pdat[ln];
        m_st[ln][7] = 1'b1;
      end
      if (wv && c == 8'h70) m_md[ln] = 1;
      return;
    end
    if (!wv) return;
    p = m_pd[ln];
    m_pd[ln] = 0;
    if (p == 1) begin
      m_md[ln] = 1;
      if (m_lk[ln][wa >> 4]) m_st[ln] |= 8'h12;
      else if (PC == 0) m_mem[ln][wa] &= d;
      else begin
        m_cnt[ln] = PC; m_pa[ln] = wa; m_pdat[ln] = d; m_st[ln][7] = 1'b0;
      end
    end else if (p == 2) begin
      m_md[ln] = 1;
      if (c == 8'h01) m_lk[ln][wa >> 4] = 1'b1;
      else if (c == 8'hD0) m_lk[ln][wa >> 4] = 1'b0;
    end else if (p == 3) begin
      m_md[ln] = 1;
      if (c == 8'hD0) begin
        if (m_lk[ln][wa >> 4]) m_st[ln] |= 8'h22;
        else for (int i = 0; i < 16; i++) m_mem[ln][(wa & 8'h30) + i] = 16'hFFFF;
      end
    end else begin
      case (c)
        8'hFF: m_md[ln] = 0;
        8'h90: m_md[ln] = 2;
        8'h98: m_md[ln] = 3;
        8'h70: m_md[ln] = 1;
        8'h50: m_st[ln] &= 8'h80;
        8'h40: m_pd[ln] = 1;
        8'h60: m_pd[ln] = 2;
        8'h20: m_pd[ln] = 3;
        default: ;
      endcase
    end
  endtask

  task automatic check_prev();
    checks++;
    if (rsp_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: rsp_valid=%b expected %b", exp_tag, rsp_valid, exp_v);
    end
    if (exp_v) begin
      checks++;
      if (rsp_data !== exp_d) begin
        fails++;
        $display("FAIL %s: rsp_data=%h expected %h", exp_tag, rsp_data, exp_d);
      end
    end
    checks++;
    if (wr_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10: wr_ready=%b expected 1", wr_ready);
    end
  endtask

  task automatic step(string tag, bit wv, int wa, logic [31:0] wd, bit rv, int ra);
    @(negedge clk);
    check_prev();
    wr_valid = wv; wr_addr = 6'(wa); wr_data = wd;
    rd_valid = rv; rd_addr = 6'(ra);
    exp_v   = rv;
    exp_tag = tag;
    if (rv) exp_d = {mread(1, ra), mread(0, ra)};
    mlane(0, wv, wa, wd[15:0]);
    mlane(1, wv, wa, wd[31:16]);
  endtask

  task automatic wr(string tag, int a, logic [31:0] d);
    step(tag, 1'b1, a, d, 1'b0, 0);
  endtask

  task automatic rd(string tag, int a);
    step(tag, 1'b0, 0, 32'h0, 1'b1, a);
  endtask

  bit done = 1'b0;

  initial begin
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < 64; i++) m_mem[l][i] = 16'hFFFF;
      for (int b = 0; b < 4; b++) m_lk[l][b] = 1'b1;
      m_st[l] = 8'h80; m_md[l] = 0; m_pd[l] = 0; m_cnt[l] = 0;
      m_pa[l] = 0; m_pdat[l] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: erased array, locked blocks, status 0x80
    rd("R1", 0); rd("R1", 17); rd("R1", 63);
    wr("R2", 0, 32'h0090_0090);
    rd("R1", 2); rd("R1", 18); rd("R1", 50);
    rd("R2", 0); rd("R2", 1); rd("R2", 3);
    wr("R2", 0, 32'h0070_0070);
    rd("R1", 0);
    wr("R2", 0, 32'h0098_0098);
    rd("R2", 4);
    wr("R2", 0, 32'h0033_0033);       // unknown byte: still query mode
    rd("R2", 4);

    // R6 program into locked block
    wr("R6", 5, 32'h0040_0040);
    wr("R6", 5, 32'h0000_0000);
    rd("R6", 5);
    wr("R6", 0, 32'h00FF_00FF);
    rd("R6", 5);
    wr("R6", 0, 32'h0070_0070);
    rd("R6", 0);
    wr("R6", 0, 32'h0050_0050);
    rd("R6", 0);
    rd("R11", 0);

    // R7 unlock block 0
    wr("R7", 3, 32'h0060_0060);
    wr("R7", 3, 32'h00D0_00D0);
    rd("R7", 0);
    wr("R7", 0, 32'h0090_0090);
    rd("R7", 2);

    // R4/R5 program with busy interval; writes ignored while busy
    wr("R4", 5, 32'h0040_0040);
    step("R5", 1'b1, 5, 32'h1234_5678, 1'b1, 0);
    step("R5", 1'b1, 0, 32'h00FF_00FF, 1'b1, 0);
    rd("R5", 0); rd("R5", 0); rd("R5", 0); rd("R5", 0);
    rd("R9", 5);
    wr("R9", 0, 32'h0090_0090);
    rd("R7", 2);
    wr("R4", 0, 32'h00FF_00FF);
    rd("R4", 5);
    wr("R4", 5, 32'h0040_0040);
    wr("R4", 5, 32'hFFFF_0F0F);
    repeat (PC) rd("R5", 0);
    wr("R4", 0, 32'h00FF_00FF);
    rd("R4", 5); rd("R4", 6);

    // R3 lanes independent: lane0 unlocks block1, lane1 locks it
    wr("R3", 20, 32'h0060_0060);
    wr("R3", 20, 32'h0001_00D0);
    wr("R3", 20, 32'h0040_0040);
    wr("R3", 20, 32'h0000_A5A5);
    rd("R3", 0); rd("R3", 0);
    wr("R3", 0, 32'h0050_0070);
    rd("R3", 0); rd("R3", 0);
    wr("R3", 0, 32'h00FF_00FF);
    rd("R3", 20);

    // R8 erase unlocked, locked and cancelled
    wr("R8", 7, 32'h0020_0020);
    wr("R8", 7, 32'h00D0_00D0);
    rd("R8", 0);
    wr("R8", 0, 32'h00FF_00FF);
    rd("R8", 5); rd("R8", 20);
    wr("R8", 40, 32'h0020_0020);
    wr("R8", 40, 32'h00D0_00D0);
    rd("R8", 0);
    wr("R8", 0, 32'h0050_0050);
    wr("R8", 20, 32'h0020_0020);
    wr("R8", 20, 32'h0011_0011);
    wr("R8", 0, 32'h00FF_00FF);
    rd("R8", 20);

    // R7 relock block 0, other second byte changes nothing
    wr("R7", 1, 32'h0060_0060);
    wr("R7", 1, 32'h0001_0001);
    wr("R7", 9, 32'h0060_0060);
    wr("R7", 9, 32'h0044_0044);
    wr("R7", 0, 32'h0090_0090);
    rd("R7", 2); rd("R7", 22);

    // R10 back-to-back reads and an idle cycle
    rd("R10", 1); rd("R10", 0);
    step("R10", 1'b0, 0, 32'h0, 1'b0, 0);
    step("R10", 1'b0, 0, 32'h0, 1'b0, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule